// File: doc/BRIEF.md
# Buffered Flash Page Program Unit

This unit sends one complete page-program transaction to a serial NOR flash over a single-lane SPI link. Software switches the unit into buffer mode, waits until the mode bit reads back set, and then writes 32 words into one push register. These words fill a 128-byte staging buffer. Software then loads the opcode and the address bytes, chooses a 3- or 4-byte address, and sets the write bit in the command register. The unit sends the opcode, the address and the whole buffer. When the last bit has left the unit, the write bit clears.

When buffer mode is off, the same command sends a frame that carries only one data byte, taken from a single-byte register. The unit does not handle write-enable sequencing, flash status polling or erase commands.

The register bus is a plain write strobe with a shared address. Reads are combinational. The SPI side works in mode 0: the clock idles low, data is sampled on the rising edge and changes on the falling edge. The SPI clock half period is a parameter counted in system clocks.

Top module: `flash_page_prog`

## Requirements
- R1: After reset, every readable register reads 0. These are the command register (0x00), address-length register (0x18), buffer-mode register (0x1C) and overflow register (0x28). Chip select is high and the SPI clock is low.
- R2: Bit 0 of the buffer-mode register (0x1C) is a request. The read-back of that bit follows the request in the clock after the write, provided no transaction is running. Clearing the request reads back 0 in the same way.
- R3: A write to the push register (0x20) adds four bytes to the buffer. Bits 7:0 are sent first and bits 31:24 are sent fourth. A push is accepted only while the buffer-mode read-back is 1; at any other time it is dropped.
- R4: A buffered frame is sent in this order: the opcode register (0x04), the address most-significant byte first, then the 128 buffer bytes in push order. Each byte is sent MSB first. The SPI clock is low whenever chip select is high, and MOSI never changes at a rising SPI clock edge.
- R5: The address bytes are held in four registers: low (0x08), mid (0x0C), high (0x10) and top (0x14). With bit 4 of the address-length register (0x18) clear, the frame carries high, mid, low. With bit 4 set, it carries top, high, mid, low.
- R6: Writing 1 to bit 4 of the command register (0x00) while idle starts a frame. Bit 4 reads 1 and chip select is low for the whole frame. Both return to idle in the clock in which the last bit finishes.
- R7: With the buffer-mode read-back at 0, a frame carries the opcode, the address and one data byte from the single-byte register (0x24).
- R8: A push made when the buffer already holds 128 bytes is dropped and sets bit 0 of the overflow register (0x28). That bit stays set until a frame completes or buffer mode is switched off.
- R9: After a frame completes, or after buffer mode is switched off, the next accepted push lands at byte 0 of the buffer.
- R10: While a frame is running, all register writes are ignored. This covers pushes, buffer-mode changes and opcode changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address for both writes and reads |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| spi_sck | output | 1 | SPI clock, mode 0 |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |

## Verification
Some properties are checked on every cycle. Chip select matches the busy bit. The clock is idle-low and MOSI is stable at each rising edge. The buffer pointer never goes past the page. Pushes and mode writes made during a frame leave the buffer, the overflow flag and the mode acknowledge untouched. The overflow flag stays set until it is cleared. The command bit drops once the frame is done.

Other behaviour only the bench scenarios can show. These are the byte order on the wire, the switch between 3- and 4-byte address lengths, the little-endian unpacking of pushed words, the single-byte frame, and the pointer returning to byte 0 after a frame completes or after buffer mode is switched off. The bench shows these by comparing every received byte against a scoreboard.

// File: rtl/fpp_pkg.sv
package fpp_pkg;

   localparam int unsigned REG_AW = 8;

   // register byte offsets
   localparam logic [REG_AW-1:0] OFS_CMD    = 8'h00;
   localparam logic [REG_AW-1:0] OFS_OPC    = 8'h04;
   localparam logic [REG_AW-1:0] OFS_ADR0   = 8'h08;
   localparam logic [REG_AW-1:0] OFS_ADR1   = 8'h0C;
   localparam logic [REG_AW-1:0] OFS_ADR2   = 8'h10;
   localparam logic [REG_AW-1:0] OFS_ADR3   = 8'h14;
   localparam logic [REG_AW-1:0] OFS_BUSCFG = 8'h18;
   localparam logic [REG_AW-1:0] OFS_BUFCFG = 8'h1C;
   localparam logic [REG_AW-1:0] OFS_PUSH   = 8'h20;
   localparam logic [REG_AW-1:0] OFS_SINGLE = 8'h24;
   localparam logic [REG_AW-1:0] OFS_STAT   = 8'h28;

   // bit positions software depends on
   localparam int unsigned BIT_CMD_WRITE = 4;
   localparam int unsigned BIT_FOUR_BYTE = 4;
   localparam int unsigned BIT_BUF_EN    = 0;
   localparam int unsigned BIT_OVF       = 0;

   typedef enum logic {
      SER_IDLE,
      SER_RUN
   } ser_state_e;

   typedef struct packed {
      logic [7:0]      opcode;
      logic [3:0][7:0] adr;
      logic [7:0]      single;
      logic            four_b;
      logic            buf_on;
   } txn_cfg_t;

endpackage

// File: rtl/fpp_regs.sv
module fpp_regs
   import fpp_pkg::*;
#(
   parameter int unsigned DATA_W       = 32,
   parameter bit          FOUR_BYTE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [REG_AW-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   input  logic              done_i,
   input  logic              ovf_i,
   output logic              busy_o,
   output logic              start_o,
   output logic              push_o,
   output logic [DATA_W-1:0] push_data_o,
   output txn_cfg_t          cfg_o
);

   if (DATA_W < 16) begin : g_chk_w
      $error("fpp_regs: DATA_W must be at least 16");
   end

   logic            busy_q;
   logic            req_q;
   logic            ack_q;
   logic            four_q;
   logic [7:0]      opc_q;
   logic [7:0]      single_q;
   logic [3:0][7:0] adr_q;
   logic            wr_ok;

   assign wr_ok       = wr_en_i && !busy_q;
   assign start_o     = wr_ok && (addr_i == OFS_CMD) && wdata_i[BIT_CMD_WRITE];
   assign push_o      = wr_en_i && (addr_i == OFS_PUSH);
   assign push_data_o = wdata_i;
   assign busy_o      = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         req_q    <= 1'b0;
         ack_q    <= 1'b0;
         opc_q    <= '0;
         single_q <= '0;
         adr_q    <= '0;
      end else begin
         if (wr_ok) begin
            case (addr_i)
               OFS_OPC:    opc_q    <= wdata_i[7:0];
               OFS_ADR0:   adr_q[0] <= wdata_i[7:0];
               OFS_ADR1:   adr_q[1] <= wdata_i[7:0];
               OFS_ADR2:   adr_q[2] <= wdata_i[7:0];
               OFS_ADR3:   adr_q[3] <= wdata_i[7:0];
               OFS_BUFCFG: req_q    <= wdata_i[BIT_BUF_EN];
               OFS_SINGLE: single_q <= wdata_i[7:0];
               default: ;
            endcase
         end
         if (!busy_q) begin
            ack_q <= req_q;
         end
         if (start_o) begin
            busy_q <= 1'b1;
         end else if (done_i) begin
            busy_q <= 1'b0;
         end
      end
   end

   generate
      if (FOUR_BYTE_EN) begin : g_four
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               four_q <= 1'b0;
            end else if (wr_ok && (addr_i == OFS_BUSCFG)) begin
               four_q <= wdata_i[BIT_FOUR_BYTE];
            end
         end
      end else begin : g_three
         assign four_q = 1'b0;
      end
   endgenerate

   always_comb begin
      cfg_o.opcode = opc_q;
      cfg_o.adr    = adr_q;
      cfg_o.single = single_q;
      cfg_o.four_b = four_q;
      cfg_o.buf_on = ack_q;
   end

   always_comb begin
      rdata_o = '0;
      case (addr_i)
         OFS_CMD:    rdata_o[BIT_CMD_WRITE] = busy_q;
         OFS_OPC:    rdata_o[7:0] = opc_q;
         OFS_ADR0:   rdata_o[7:0] = adr_q[0];
         OFS_ADR1:   rdata_o[7:0] = adr_q[1];
         OFS_ADR2:   rdata_o[7:0] = adr_q[2];
         OFS_ADR3:   rdata_o[7:0] = adr_q[3];
         OFS_BUSCFG: rdata_o[BIT_FOUR_BYTE] = four_q;
         OFS_BUFCFG: rdata_o[BIT_BUF_EN] = ack_q;
         OFS_SINGLE: rdata_o[7:0] = single_q;
         OFS_STAT:   rdata_o[BIT_OVF] = ovf_i;
         default: ;
      endcase
   end

   AST_CMD_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |=> !busy_q); // R6
   AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && wr_en_i && (addr_i == OFS_BUFCFG) |=> $stable(ack_q)); // R10

endmodule

// File: rtl/fpp_wbuf.sv
module fpp_wbuf #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned PAGE_BYTES = 128
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          en_i,
   input  logic                          busy_i,
   input  logic                          clr_i,
   input  logic                          push_i,
   input  logic [DATA_W-1:0]             push_data_i,
   input  logic [$clog2(PAGE_BYTES)-1:0] rd_off_i,
   output logic [7:0]                    rd_byte_o,
   output logic                          ovf_o
);

   localparam int unsigned BPW    = DATA_W / 8;
   localparam int unsigned DEPTH  = PAGE_BYTES / BPW;
   localparam int unsigned OFF_W  = $clog2(PAGE_BYTES);
   localparam int unsigned LANE_W = $clog2(BPW);
   localparam int unsigned WA_W   = OFF_W - LANE_W;
   localparam int unsigned PTR_W  = $clog2(PAGE_BYTES + 1);

   if ((DATA_W % 8) != 0 || BPW < 2 || (BPW & (BPW - 1)) != 0) begin : g_chk_w
      $error("fpp_wbuf: DATA_W must be a power-of-two byte multiple of at least 16");
   end
   if ((PAGE_BYTES & (PAGE_BYTES - 1)) != 0 || PAGE_BYTES < 2 * BPW) begin : g_chk_p
      $error("fpp_wbuf: PAGE_BYTES must be a power of two of at least two words");
   end

   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [PTR_W-1:0]  ptr_q;
   logic              ovf_q;
   logic              accept;
   logic              full;

   assign accept = push_i && en_i && !busy_i;
   assign full   = (ptr_q == PTR_W'(PAGE_BYTES));
   assign ovf_o  = ovf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
         ovf_q <= 1'b0;
      end else if (clr_i || !en_i) begin
         ptr_q <= '0;
         ovf_q <= 1'b0;
      end else if (accept) begin
         if (full) begin
            ovf_q <= 1'b1;
         end else begin
            ptr_q <= ptr_q + PTR_W'(BPW);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (accept && !full && en_i && !clr_i) begin
         mem_q[ptr_q[LANE_W +: WA_W]] <= push_data_i;
      end
   end

   assign rd_byte_o = mem_q[rd_off_i[OFF_W-1:LANE_W]][{rd_off_i[LANE_W-1:0], 3'b000} +: 8];

   AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_q <= PTR_W'(PAGE_BYTES)); // R8
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q && !clr_i && en_i |=> ovf_q); // R8
   AST_PUSH_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i && push_i && !clr_i && en_i |=> $stable(ptr_q) && $stable(ovf_q)); // R10
   AST_PTR_RESET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en_i) |=> (ptr_q == '0)); // R9

endmodule

// File: rtl/fpp_serial.sv
module fpp_serial
   import fpp_pkg::*;
#(
   parameter int unsigned HALF_CYC = 2,
   parameter int unsigned IDX_W    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [IDX_W-1:0] last_idx_i,
   input  logic [7:0]       fetch_byte_i,
   output logic [IDX_W-1:0] fetch_idx_o,
   output logic             done_o,
   output logic             sck_o,
   output logic             cs_n_o,
   output logic             mosi_o
);

   localparam int unsigned DIV_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

   if (HALF_CYC < 1) begin : g_chk_h
      $error("fpp_serial: HALF_CYC must be at least 1");
   end

   ser_state_e       st_q;
   logic [DIV_W-1:0] div_q;
   logic [7:0]       shr_q;
   logic [2:0]       bit_q;
   logic [IDX_W-1:0] idx_q;
   logic             sck_q;
   logic             cs_n_q;
   logic             tick;
   logic             byte_end;

   assign tick        = (div_q == DIV_W'(HALF_CYC - 1));
   assign byte_end    = sck_q && (bit_q == 3'd0);
   assign done_o      = (st_q == SER_RUN) && tick && byte_end && (idx_q == last_idx_i);
   assign fetch_idx_o = (st_q == SER_IDLE) ? '0 : idx_q + IDX_W'(1);
   assign sck_o       = sck_q;
   assign cs_n_o      = cs_n_q;
   assign mosi_o      = shr_q[7];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SER_IDLE;
         div_q  <= '0;
         shr_q  <= '0;
         bit_q  <= '0;
         idx_q  <= '0;
         sck_q  <= 1'b0;
         cs_n_q <= 1'b1;
      end else if (st_q == SER_IDLE) begin
         if (start_i) begin
            st_q   <= SER_RUN;
            cs_n_q <= 1'b0;
            shr_q  <= fetch_byte_i;
            bit_q  <= 3'd7;
            idx_q  <= '0;
            div_q  <= '0;
            sck_q  <= 1'b0;
         end
      end else begin
         if (!tick) begin
            div_q <= div_q + DIV_W'(1);
         end else begin
            div_q <= '0;
            if (!sck_q) begin
               sck_q <= 1'b1;
            end else begin
               sck_q <= 1'b0;
               if (bit_q == 3'd0) begin
                  if (idx_q == last_idx_i) begin
                     st_q   <= SER_IDLE;
                     cs_n_q <= 1'b1;
                  end else begin
                     shr_q <= fetch_byte_i;
                     idx_q <= idx_q + IDX_W'(1);
                     bit_q <= 3'd7;
                  end
               end else begin
                  shr_q <= {shr_q[6:0], 1'b0};
                  bit_q <= bit_q - 3'd1;
               end
            end
         end
      end
   end

   AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_q |-> !sck_q); // R4
   AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sck_q) |-> $stable(mosi_o)); // R4

endmodule

// File: rtl/flash_page_prog.sv
module flash_page_prog
   import fpp_pkg::*;
#(
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned PAGE_BYTES   = 128,
   parameter int unsigned HALF_CYC     = 2,
   parameter bit          FOUR_BYTE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              spi_sck,
   output logic              spi_cs_n,
   output logic              spi_mosi
);

   localparam int unsigned IDX_W = $clog2(PAGE_BYTES + 6);
   localparam int unsigned OFF_W = $clog2(PAGE_BYTES);

   txn_cfg_t          cfg;
   logic              busy_w;
   logic              start_w;
   logic              push_w;
   logic [DATA_W-1:0] push_data_w;
   logic              done_w;
   logic              ovf_w;
   logic [IDX_W-1:0]  fetch_idx;
   logic [IDX_W-1:0]  last_idx;
   logic [7:0]        fetch_byte;
   logic [7:0]        buf_byte;
   logic [OFF_W-1:0]  data_off;
   logic [2:0]        alen;

   fpp_regs #(
      .DATA_W      (DATA_W),
      .FOUR_BYTE_EN(FOUR_BYTE_EN)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en_i    (reg_wr),
      .addr_i     (reg_addr),
      .wdata_i    (reg_wdata),
      .rdata_o    (reg_rdata),
      .done_i     (done_w),
      .ovf_i      (ovf_w),
      .busy_o     (busy_w),
      .start_o    (start_w),
      .push_o     (push_w),
      .push_data_o(push_data_w),
      .cfg_o      (cfg)
   );

   fpp_wbuf #(
      .DATA_W    (DATA_W),
      .PAGE_BYTES(PAGE_BYTES)
   ) u_wbuf (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (cfg.buf_on),
      .busy_i     (busy_w),
      .clr_i      (done_w),
      .push_i     (push_w),
      .push_data_i(push_data_w),
      .rd_off_i   (data_off),
      .rd_byte_o  (buf_byte),
      .ovf_o      (ovf_w)
   );

   fpp_serial #(
      .HALF_CYC(HALF_CYC),
      .IDX_W   (IDX_W)
   ) u_serial (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_w),
      .last_idx_i  (last_idx),
      .fetch_byte_i(fetch_byte),
      .fetch_idx_o (fetch_idx),
      .done_o      (done_w),
      .sck_o       (spi_sck),
      .cs_n_o      (spi_cs_n),
      .mosi_o      (spi_mosi)
   );

   assign alen     = cfg.four_b ? 3'd4 : 3'd3;
   assign last_idx = IDX_W'(alen) + (cfg.buf_on ? IDX_W'(PAGE_BYTES) : IDX_W'(1));

   // frame layout: opcode, address MSB first, then payload
   always_comb begin
      data_off = OFF_W'(fetch_idx - IDX_W'(alen) - IDX_W'(1));
      if (fetch_idx == '0) begin
         fetch_byte = cfg.opcode;
      end else if (fetch_idx <= IDX_W'(alen)) begin
         fetch_byte = cfg.adr[2'(IDX_W'(alen) - fetch_idx)];
      end else begin
         fetch_byte = cfg.buf_on ? buf_byte : cfg.single;
      end
   end

   AST_CS_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy_w |-> !spi_cs_n); // R6
   AST_CS_HIGH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_w |-> spi_cs_n); // R6

endmodule

// File: tb/flash_page_prog_test.sv
module flash_page_prog_test;
   import fpp_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        spi_sck;
   logic        spi_cs_n;
   logic        spi_mosi;

   int          n_chk = 0;
   int          n_err = 0;
   string       cur_req = "R1";
   logic [7:0]  exp_q[$];
   int          bitc = 0;
   logic [7:0]  shv = '0;

   flash_page_prog uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_wr   (reg_wr),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .spi_sck  (spi_sck),
      .spi_cs_n (spi_cs_n),
      .spi_mosi (spi_mosi)
   );

   always #10 clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1;
      reg_addr = a;
      reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #2;
      d = reg_rdata;
   endtask

   // driver: pushes words and records the bytes expected on the wire
   task automatic push_words(input int n, input int seed, input bit expect_it);
      for (int i = 0; i < n; i++) begin
         logic [31:0] w;
         for (int b = 0; b < 4; b++) w[b*8 +: 8] = 8'((i * 4 + b) * 13 + seed);
         reg_write(OFS_PUSH, w);
         if (expect_it && i < 32)
            for (int b = 0; b < 4; b++) exp_q.push_back(w[b*8 +: 8]);
      end
   endtask

   task automatic start_frame(input string req);
      logic [31:0] d;
      cur_req = req;
      reg_write(OFS_CMD, 32'h10);
      reg_read(OFS_CMD, d);
      chk("R6 busy bit set", d, 32'h10);
      chk("R6 cs low in frame", {31'd0, spi_cs_n}, 32'd0);
   endtask

   task automatic finish_frame();
      logic [31:0] d;
      d = 32'h10;
      for (int k = 0; k < 20000 && d[4]; k++) reg_read(OFS_CMD, d);
      chk("R6 busy bit cleared", d, 32'd0);
      chk("R6 cs high after frame", {31'd0, spi_cs_n}, 32'd1);
      chk("R4 frame length (bytes left)", exp_q.size(), 32'd0);
      chk("R4 no partial byte", bitc, 32'd0);
      exp_q.delete();
   endtask

   // monitor: assembles bytes at rising SPI clock and compares with the queue
   always @(posedge spi_sck) begin
      if (!spi_cs_n) begin
         shv = {shv[6:0], spi_mosi};
         bitc++;
         if (bitc == 8) begin
            bitc = 0;
            n_chk++;
            if (exp_q.size() == 0) begin
               n_err++;
               $display("FAIL %s: unexpected byte actual %h expected none", cur_req, shv);
            end else begin
               logic [7:0] e;
               e = exp_q.pop_front();
               if (shv !== e) begin
                  n_err++;
                  $display("FAIL %s: wire byte actual %h expected %h", cur_req, shv, e);
               end
            end
         end
      end
   end

   always @(negedge spi_cs_n) begin
      bitc = 0;
      chk("R4 sck low at frame start", {31'd0, spi_sck}, 32'd0);
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      reg_read(OFS_CMD, d);    chk("R1 command", d, 32'd0);
      reg_read(OFS_BUFCFG, d); chk("R1 buffer mode", d, 32'd0);
      reg_read(OFS_BUSCFG, d); chk("R1 address length", d, 32'd0);
      reg_read(OFS_STAT, d);   chk("R1 overflow", d, 32'd0);
      chk("R1 cs high", {31'd0, spi_cs_n}, 32'd1);
      chk("R1 sck low", {31'd0, spi_sck}, 32'd0);

      // R3 push while disabled is dropped, R2 enable handshake
      reg_write(OFS_PUSH, 32'hDEADBEEF);
      reg_write(OFS_BUFCFG, 32'h1);
      reg_read(OFS_BUFCFG, d); chk("R2 enable read-back", d, 32'd1);

      // first frame: 3-byte address, top register must not appear (R5)
      reg_write(OFS_OPC, 32'h02);
      reg_write(OFS_ADR0, 32'h56);
      reg_write(OFS_ADR1, 32'h34);
      reg_write(OFS_ADR2, 32'h12);
      reg_write(OFS_ADR3, 32'h9A);
      exp_q.push_back(8'h02); exp_q.push_back(8'h12);
      exp_q.push_back(8'h34); exp_q.push_back(8'h56);
      push_words(32, 5, 1'b1);
      reg_read(OFS_STAT, d); chk("R8 full buffer no overflow", d, 32'd0);
      start_frame("R3/R4/R5 three-byte frame");
      // R10 writes during the frame are ignored
      reg_write(OFS_PUSH, 32'hFFFFFFFF);
      reg_write(OFS_BUFCFG, 32'h0);
      reg_write(OFS_OPC, 32'hEE);
      reg_read(OFS_STAT, d);   chk("R10 push while busy ignored", d, 32'd0);
      reg_read(OFS_BUFCFG, d); chk("R10 mode change while busy ignored", d, 32'd1);
      reg_read(OFS_OPC, d);    chk("R10 opcode write while busy ignored", d, 32'h02);
      finish_frame();
      reg_read(OFS_BUFCFG, d); chk("R10 mode still on after frame", d, 32'd1);

      // second frame: 4-byte address, overflow push, pointer restart (R9)
      reg_write(OFS_BUSCFG, 32'h10);
      reg_write(OFS_OPC, 32'h12);
      reg_write(OFS_ADR0, 32'h44);
      reg_write(OFS_ADR1, 32'h33);
      reg_write(OFS_ADR2, 32'h22);
      reg_write(OFS_ADR3, 32'h11);
      reg_read(OFS_BUSCFG, d); chk("R5 four-byte mode read-back", d, 32'h10);
      exp_q.push_back(8'h12); exp_q.push_back(8'h11); exp_q.push_back(8'h22);
      exp_q.push_back(8'h33); exp_q.push_back(8'h44);
      push_words(33, 77, 1'b1);
      reg_read(OFS_STAT, d); chk("R8 overflow flag set", d, 32'd1);
      start_frame("R5/R8/R9 four-byte frame");
      finish_frame();
      reg_read(OFS_STAT, d); chk("R8 overflow cleared by completion", d, 32'd0);

      // disable path: overflow and pointer cleared by switching mode off
      push_words(33, 9, 1'b0);
      reg_read(OFS_STAT, d); chk("R8 overflow set again", d, 32'd1);
      reg_write(OFS_BUFCFG, 32'h0);
      reg_read(OFS_BUFCFG, d); chk("R2 disable read-back", d, 32'd0);
      reg_read(OFS_STAT, d);   chk("R9 overflow cleared by disable", d, 32'd0);
      reg_write(OFS_BUFCFG, 32'h1);
      reg_read(OFS_BUFCFG, d); chk("R2 re-enable read-back", d, 32'd1);
      reg_write(OFS_BUSCFG, 32'h0);
      reg_write(OFS_OPC, 32'h32);
      exp_q.push_back(8'h32); exp_q.push_back(8'h22);
      exp_q.push_back(8'h33); exp_q.push_back(8'h44);
      push_words(32, 101, 1'b1);
      start_frame("R9 pointer restart after disable");
      finish_frame();

      // R7 single-byte frame
      reg_write(OFS_BUFCFG, 32'h0);
      reg_read(OFS_BUFCFG, d); chk("R7 buffer mode off", d, 32'd0);
      reg_write(OFS_SINGLE, 32'hA5);
      reg_write(OFS_OPC, 32'h02);
      exp_q.push_back(8'h02); exp_q.push_back(8'h22); exp_q.push_back(8'h33);
      exp_q.push_back(8'h44); exp_q.push_back(8'hA5);
      start_frame("R7 single-byte frame");
      finish_frame();

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule